// File: doc/BRIEF.md
# Token Retry Delay Timer

This block times the pause a USB host token engine waits before it sends a token again. Software programs an 18-bit delay, counted in bit times, into a reload register made of byte-wide lanes. When the token engine starts a token while retry mode is on, the timer copies the delay into an internal down-counter. It then lowers the counter by one on every bit-time tick. When a tick arrives with the counter already at zero, the timer sends a one-cycle resend strobe back to the token engine and goes idle.

Near the end of a frame, the engine raises a hold input that covers the end-of-frame guard region and the start-of-frame packet that follows. While hold is high the counter keeps its value and ignores ticks. When hold falls, counting carries on from the value it had, instead of starting again from the reload value.

The reload register has two write restrictions. Writes are dropped while the controller's soft reset is asserted, and soft reset does not clear the register. In device mode, the low sixteen bits read as zero and refuse writes.

Top module: `retry_timer_top`

## Requirements
- R1: After the synchronous active-low reset, `busy` and `resend` are 0, `count` is 0 and `reload_rd` is 0.
- R2: A cycle with `tok_start`=1 and `retry_en`=1 sets `busy` and loads `count` with the current `reload_rd` at the next edge. `tok_start` with `retry_en`=0 has no effect on `busy`, `count` or `resend`.
- R3: While `busy`, a cycle with `bit_tick`=1 and `eof_hold`=0 lowers a nonzero `count` by exactly one. Without a tick, `count` holds.
- R4: While `busy`, a tick that is not held and finds `count` at 0 makes `resend` 1 for exactly one cycle after that edge. `busy` falls at the same edge, and the timer stays idle until the next arming.
- R5: When `reload_rd` is 0, `resend` pulses after the first unheld tick that follows arming.
- R6: While `eof_hold`=1, `count` does not change and no resend is issued. After hold falls, counting resumes from the held value.
- R7: Arming while already `busy` restarts `count` from `reload_rd`.
- R8: Writes select a lane with `cfg_lane`: 0 writes bits 7:0, 1 writes bits 15:8, and 2 writes bits 17:16 from `cfg_wdata[1:0]`. Bits 7:2 of a lane-2 write are discarded. Lane code 3 writes nothing.
- R9: While `soft_rst`=1, register writes are ignored and the stored value is kept.
- R10: With `host_mode`=0, `reload_rd[15:0]` reads 0, writes to lanes 0 and 1 are ignored, lane 2 stays writable, and arming loads the value as read.
- R11: When arming and an unheld tick happen in the same cycle, the load wins and the tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Controller soft reset; blocks register writes |
| host_mode | input | 1 | 1 = host mode, 0 = device mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_lane | input | 2 | Byte lane selected by the write |
| cfg_wdata | input | 8 | Write data for the selected lane |
| reload_rd | output | 18 | Visible reload value |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| retry_en | input | 1 | Retry mode enable |
| tok_start | input | 1 | Token send start pulse |
| eof_hold | input | 1 | End-of-frame / SOF interval; freezes counting |
| resend | output | 1 | One-cycle strobe to resend the token |
| busy | output | 1 | Timer armed and counting |
| count | output | 18 | Current counter value |

## Verification
The assertions assume that `host_mode` changes only between writes. The check on blocked writes allows a reload value to differ only when `host_mode` moved in that cycle. They also assume that the reload value visible in the arming cycle is the one loaded, even if a write lands in that same cycle. The stimulus changes `host_mode` only on cycles with no write. It also mixes writes with arming on purpose, so the loaded value is always the value read before the write.

// File: rtl/rtr_pkg.sv
// Shared types for the token retry delay timer.
package rtr_pkg;

    // Sequencer state: waiting for arming, or counting down
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rtr_state_e;

    // Number of byte lanes needed to cover a value width
    function automatic int lane_count(input int width, input int lane_w);
        return (width + lane_w - 1) / lane_w;
    endfunction

endpackage

// File: rtl/rtr_reload_regs.sv
// Reload register split into byte lanes.
// Assumes: bits below HOST_ONLY_W exist only in host mode; soft reset
// blocks writes but never clears the stored value.
module rtr_reload_regs
    import rtr_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int LANE_W      = 8,
    parameter int HOST_ONLY_W = 16,
    localparam int NUM_LANES  = lane_count(CNT_W, LANE_W),
    localparam int SEL_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              host_mode,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_lane,
    input  logic [LANE_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0]  vis_val
);

    logic [CNT_W-1:0] stored;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LO        = g * LANE_W;
        localparam int HI        = ((LO + LANE_W) < CNT_W) ? (LO + LANE_W - 1) : (CNT_W - 1);
        localparam int W         = HI - LO + 1;
        localparam bit HOST_ONLY = (HI < HOST_ONLY_W);

        logic [W-1:0] lane_q;
        logic         wr_ok;

        // Write is accepted only outside soft reset and, for host-only lanes, in host mode
        assign wr_ok = cfg_we && !soft_rst && (cfg_lane == SEL_W'(g))
                       && (host_mode || !HOST_ONLY);

        // Lane storage: cleared by hardware reset only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_ok) begin
                lane_q <= cfg_wdata[W-1:0];
            end
        end

        assign stored[HI:LO] = lane_q;
    end

    // Device mode hides the host-only bits
    always_comb begin
        vis_val = stored;
        if (!host_mode) begin
            vis_val[HOST_ONLY_W-1:0] = '0;
        end
    end

endmodule

// File: rtl/rtr_countdown.sv
// Loadable down-counter with a zero flag.
// Assumes: load and dec are never both high (the sequencer gives load priority).
module rtr_countdown #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Counter register: load has priority over decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt     = cnt_q;
    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/rtr_seq.sv
// Arming / expiry sequencer for the retry timer.
// Assumes: bit_tick is a one-cycle pulse per bit time; eof_hold covers the
// end-of-frame guard and the start-of-frame packet that follows.
module rtr_seq
    import rtr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tok_start,
    input  logic retry_en,
    input  logic bit_tick,
    input  logic eof_hold,
    input  logic at_zero,
    output logic load,
    output logic dec,
    output logic busy,
    output logic resend
);

    rtr_state_e state_q;
    logic       arm, step, fire, resend_q;

    assign arm  = tok_start && retry_en;
    assign step = (state_q == ST_RUN) && bit_tick && !eof_hold;
    assign fire = step && at_zero && !arm;
    assign load = arm;
    assign dec  = step && !at_zero && !arm;

    // State and strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resend_q <= 1'b0;
        end else begin
            resend_q <= fire;
            if (arm) begin
                state_q <= ST_RUN;
            end else if (fire) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign resend = resend_q;

endmodule

// File: rtl/retry_timer_top.sv
// Token retry delay timer: reload lanes, sequencer and down-counter.
// Assumes: inputs are synchronous to clk.
module retry_timer_top
    import rtr_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int LANE_W      = 8,
    parameter int HOST_ONLY_W = 16,
    localparam int NUM_LANES  = lane_count(CNT_W, LANE_W),
    localparam int SEL_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              host_mode,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_lane,
    input  logic [LANE_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0]  reload_rd,
    input  logic              bit_tick,
    input  logic              retry_en,
    input  logic              tok_start,
    input  logic              eof_hold,
    output logic              resend,
    output logic              busy,
    output logic [CNT_W-1:0]  count
);

    logic load, dec, at_zero;

    rtr_reload_regs #(
        .CNT_W(CNT_W), .LANE_W(LANE_W), .HOST_ONLY_W(HOST_ONLY_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_mode(host_mode),
        .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_wdata(cfg_wdata),
        .vis_val(reload_rd)
    );

    rtr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .retry_en(retry_en),
        .bit_tick(bit_tick), .eof_hold(eof_hold), .at_zero(at_zero),
        .load(load), .dec(dec), .busy(busy), .resend(resend)
    );

    rtr_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reload_rd),
        .dec(dec), .cnt(count), .at_zero(at_zero)
    );

endmodule

// File: rtl/retry_timer_chk.sv
// Property checker for retry_timer_top, attached by bind.
module retry_timer_chk #(
    parameter int CNT_W       = 18,
    parameter int HOST_ONLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             host_mode,
    input logic             cfg_we,
    input logic [CNT_W-1:0] reload_rd,
    input logic             bit_tick,
    input logic             retry_en,
    input logic             tok_start,
    input logic             eof_hold,
    input logic             resend,
    input logic             busy,
    input logic [CNT_W-1:0] count
);

    // R2: arming loads the visible reload value
    p_arm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_start && retry_en) |=> (busy && count == $past(reload_rd)));

    // R2: tok_start without retry enable leaves an idle timer idle
    p_no_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(tok_start && retry_en)) |=> !busy);

    // R3: one step down per unheld tick
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_tick && !eof_hold && count != '0 && !(tok_start && retry_en))
        |=> (count == $past(count) - CNT_W'(1)));

    // R4: the resend strobe lasts one cycle
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resend |=> !resend);

    // R4: resend only follows an unheld tick at zero, and the timer is idle then
    p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resend) |-> (!busy && $past(busy && bit_tick && !eof_hold && count == '0)));

    // R6: the count is frozen during hold
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eof_hold && !(tok_start && retry_en)) |=> ($stable(count) && !resend));

    // R9: writes during soft reset leave the value unchanged
    p_softrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && cfg_we) |=> (reload_rd == $past(reload_rd) || host_mode != $past(host_mode)));

    // R10: host-only bits read zero in device mode
    p_devzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> (reload_rd[HOST_ONLY_W-1:0] == '0));

endmodule

bind retry_timer_top retry_timer_chk #(.CNT_W(CNT_W), .HOST_ONLY_W(HOST_ONLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_mode(host_mode),
    .cfg_we(cfg_we), .reload_rd(reload_rd), .bit_tick(bit_tick),
    .retry_en(retry_en), .tok_start(tok_start), .eof_hold(eof_hold),
    .resend(resend), .busy(busy), .count(count)
);

// File: tb/sim_retry_timer_top.sv
// Testbench: behavioural reference model compared on every clock.
module sim_retry_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, host_mode = 1'b1, cfg_we = 1'b0;
    logic [1:0]  cfg_lane = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        bit_tick = 1'b0, retry_en = 1'b0, tok_start = 1'b0, eof_hold = 1'b0;
    logic [17:0] reload_rd, count;
    logic        resend, busy;

    int total = 0, bad = 0;
    bit done = 0;

    int m_reg [3];
    int m_cnt = 0;
    bit m_busy = 0, m_resend = 0;

    always #2 clk = ~clk;

    retry_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_mode(host_mode),
        .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_wdata(cfg_wdata),
        .reload_rd(reload_rd), .bit_tick(bit_tick), .retry_en(retry_en),
        .tok_start(tok_start), .eof_hold(eof_hold), .resend(resend),
        .busy(busy), .count(count)
    );

    function automatic int vis();
        return (m_reg[2] << 16) | (host_mode ? ((m_reg[1] << 8) | m_reg[0]) : 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model update with the inputs present at the edge
    task automatic model_edge();
        bit nres = 0;
        if (!rst_n) begin
            m_reg = '{0, 0, 0}; m_cnt = 0; m_busy = 0; m_resend = 0;
        end else begin
            int v = vis();
            if (tok_start && retry_en) begin
                m_busy = 1; m_cnt = v;
            end else if (m_busy && bit_tick && !eof_hold) begin
                if (m_cnt == 0) begin m_busy = 0; nres = 1; end
                else m_cnt--;
            end
            m_resend = nres;
            if (cfg_we && !soft_rst) begin
                if (cfg_lane == 2'd2) m_reg[2] = int'(cfg_wdata) & 3;
                else if (cfg_lane < 2'd2 && host_mode) m_reg[cfg_lane] = int'(cfg_wdata);
            end
        end
    endtask

    // One clock: drive, update model at edge, compare away from the edge
    task automatic cyc(input bit tk, input bit re, input bit ts, input bit eh);
        bit_tick = tk; retry_en = re; tok_start = ts; eof_hold = eh;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R4 resend", int'(resend), int'(m_resend));
        chk("R2 busy", int'(busy), int'(m_busy));
        chk("R3 count", int'(count), m_cnt);
        chk("R8 reload_rd", int'(reload_rd), vis());
        cfg_we = 0;
    endtask

    task automatic wr(input logic [1:0] lane, input logic [7:0] d);
        cfg_we = 1; cfg_lane = lane; cfg_wdata = d;
        cyc(0, 0, 0, 0);
    endtask

    task automatic set_reload(input int v);
        wr(2'd0, 8'(v)); wr(2'd1, 8'(v >> 8)); wr(2'd2, 8'(v >> 16));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(0, 0, 0, 0);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 resend", int'(resend), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 reload_rd", int'(reload_rd), 0);
        rst_n = 1;
        cyc(0, 0, 0, 0);

        // R8: lane mapping and discarded top bits
        wr(2'd0, 8'h34); wr(2'd1, 8'h12); wr(2'd2, 8'hFE);
        chk("R8 lanes", int'(reload_rd), 32'h21234);
        wr(2'd3, 8'hAA);
        chk("R8 lane3", int'(reload_rd), 32'h21234);

        // R2: tok_start without retry enable does nothing
        set_reload(3);
        cyc(0, 0, 1, 0);
        chk("R2 no arm", int'(busy), 0);

        // R2/R3/R4: arm, count down, single resend
        cyc(0, 1, 1, 0);
        chk("R2 armed", int'(count), 3);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        chk("R3 at zero", int'(count), 0);
        cyc(1, 0, 0, 0);
        chk("R4 pulse", int'(resend), 1);
        chk("R4 idle", int'(busy), 0);
        cyc(1, 0, 0, 0);
        chk("R4 one cycle", int'(resend), 0);

        // R5: zero reload fires on the first tick
        set_reload(0);
        cyc(0, 1, 1, 0);
        cyc(1, 0, 0, 0);
        chk("R5 immediate", int'(resend), 1);

        // R6: freeze and resume
        set_reload(10);
        cyc(0, 1, 1, 0);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 1);
        chk("R6 frozen", int'(count), 8);
        cyc(1, 0, 0, 0);
        chk("R6 resumed", int'(count), 7);

        // R7: re-arm restarts from the reload value
        cyc(0, 1, 1, 0);
        chk("R7 restart", int'(count), 10);

        // R11: arming beats a simultaneous tick
        cyc(1, 1, 1, 0);
        chk("R11 load wins", int'(count), 10);

        // R9: writes blocked in soft reset, value kept
        soft_rst = 1;
        wr(2'd0, 8'h55); wr(2'd2, 8'h03);
        chk("R9 kept", int'(reload_rd), 10);
        soft_rst = 0;
        cyc(0, 0, 0, 0);

        // R10: device mode
        set_reload(32'h1ABCD);
        host_mode = 0;
        cyc(0, 0, 0, 0);
        chk("R10 low zero", int'(reload_rd), 32'h10000);
        wr(2'd0, 8'h11); wr(2'd2, 8'h02);
        chk("R10 lane2 only", int'(reload_rd), 32'h20000);
        cyc(0, 1, 1, 0);
        chk("R10 load vis", int'(count), 32'h20000);
        host_mode = 1;
        cyc(0, 0, 0, 0);
        chk("R10 lane0 kept", int'(reload_rd), 32'h2ABCD);

        // Mixed random traffic against the model
        set_reload(5);
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) begin
                cfg_we = 1; cfg_lane = 2'($urandom % 2); cfg_wdata = 8'($urandom % 8);
                soft_rst = (($urandom % 4) == 0);
            end else begin
                soft_rst = 0;
                if (($urandom % 300) == 0) host_mode = ~host_mode;
            end
            cyc(($urandom % 3) != 0, ($urandom % 4) != 0,
                ($urandom % 40) == 0, ($urandom % 6) == 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule